// File: doc/BRIEF.md
# I2C Slave Byte Engine with Flag-Gated Clock Stretching

This block is the target side of an I2C link. It watches the open-drain SCL and SDA lines and recognises start and stop conditions. It compares the first byte of each transfer with its own 7-bit address. When the address matches, it acknowledges and then moves bytes in the direction that the read/write bit of that byte selects. One shift register serves all three phases (address, receive and transmit). Software supplies outgoing bytes through a transmit data register and collects incoming bytes from a receive data register.

Four sticky status flags tell software what has happened on the bus: stop seen, transmit register free, byte sent and byte received. Each flag stays set until software writes a 1 to its bit. Two control bits link those flags to clock stretching. With the single-buffer bit set, the engine pulls SCL low while the transmit-free flag is pending. With the receive-stall bit set, it pulls SCL low while the byte-received flag is pending. A slow processor can therefore pace the master without losing data.

The register port is a plain synchronous write strobe with an address and a combinational read mux. It has no back-pressure: a write takes effect on the clock edge where `reg_wr` is high, and `reg_rdata` follows `reg_addr` in the same cycle. Register offsets are: 0 transmit data (read/write), 1 receive data (read only), 2 control, 3 status.

Top module: `i2c_stretch_slave`

## Requirements
- R1: After reset, SCL and SDA are both released, all status flags read as 0, and the control register and receive data register read as 0.
- R2: The engine pulls SDA low in the ninth clock of the first byte after a start only when bits 7..1 of that byte equal the `SLAVE_ADDR` parameter; for any other address SDA stays released and no transfer flag sets.
- R3: In a write transfer (bit 0 of the address byte = 0), each byte is shifted in MSB first and acknowledged. After its eighth SCL falling edge, the byte is readable at offset 1 and status bit 3 (byte received) is set.
- R4: In a read transfer (bit 0 = 1), offset 0 is copied into the shift register on the SCL falling edge that precedes each byte's first bit, and status bit 1 (transmit free) sets there. The byte goes out MSB first. Status bit 2 (byte sent) sets after the eighth SCL falling edge.
- R5: When the master answers a transmitted byte with NACK (SDA high in the ninth clock), the engine drives SDA no more until the next start or stop.
- R6: Status bit 0 (stop seen) sets when SDA rises while SCL is high.
- R7: Writing offset 3 clears each status flag whose data bit is 1. A flag whose data bit is 0 keeps its value.
- R8: With control bit 0 (single buffer) set, the engine holds SCL low during an addressed transfer while status bit 1 is set. It releases SCL once software clears that flag.
- R9: With control bit 1 (receive stall) set, SCL is held low from the capture of a received byte until status bit 3 is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Resolved level of the SCL line |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_i | input | 1 | Resolved level of the SDA line |
| sda_oe | output | 1 | 1 pulls SDA low (ACK or data 0) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |

## Verification
The assertions assume a well-behaved master. It moves SDA only while SCL is low, except to form a start or a stop. Each SCL low phase outlasts the synchroniser delay, so a released hold never meets a master edge that is still in flight. The bench master follows these rules. It changes SDA several cycles after it lowers SCL, keeps each phase at 16 system cycles, and after releasing SCL waits for the resolved line to go high, so every stretch is respected. Random byte values, lengths and directions come from a seeded generator. Directed cases cover the stretch, NACK and address-mismatch paths.

// File: rtl/i2c_stretch_pkg.sv
package i2c_stretch_pkg;
  localparam int BYTE_W = 8;
  localparam int NFLAG  = 4;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK, ST_SKIP
  } eng_state_e;

  localparam logic [1:0] OFS_TX   = 2'd0;
  localparam logic [1:0] OFS_RX   = 2'd1;
  localparam logic [1:0] OFS_CTRL = 2'd2;
  localparam logic [1:0] OFS_STAT = 2'd3;

  localparam int FL_STOP = 0;
  localparam int FL_TXE  = 1;
  localparam int FL_TXD  = 2;
  localparam int FL_RXF  = 3;

  localparam int CT_SBUF  = 0;
  localparam int CT_STALL = 1;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_s,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] pipe_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pipe_q <= '1;
      prev_q <= 1'b1;
    end else begin
      pipe_q <= {pipe_q[STAGES-2:0], line_i};
      prev_q <= pipe_q[STAGES-1];
    end
  end

  assign line_s = pipe_q[STAGES-1];
  assign rise   = line_s & ~prev_q;
  assign fall   = ~line_s & prev_q;
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_stretch_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h2A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  input  logic              sda_rise,
  input  logic              sda_fall,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_cap,
  output logic              tx_load,
  output logic              tx_done,
  output logic              stop_seen,
  output logic              addressed
);
  eng_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic              rw_q;
  logic              mnack_q;
  logic              start_c, stop_c;

  assign start_c = sda_fall & scl_s;
  assign stop_c  = sda_rise & scl_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      sh_q      <= '0;
      rw_q      <= 1'b0;
      mnack_q   <= 1'b1;
      rx_cap    <= 1'b0;
      tx_load   <= 1'b0;
      tx_done   <= 1'b0;
      stop_seen <= 1'b0;
    end else begin
      rx_cap    <= 1'b0;
      tx_load   <= 1'b0;
      tx_done   <= 1'b0;
      stop_seen <= 1'b0;
      if (stop_c) begin
        state_q   <= ST_IDLE;
        stop_seen <= 1'b1;
      end else if (start_c) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
      end else begin
        case (state_q)
          ST_ADDR, ST_RX: begin
            if (scl_rise) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_s};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == CNT_W'(BYTE_W)) begin
              cnt_q <= '0;
              if (state_q == ST_RX) begin
                rx_cap  <= 1'b1;
                state_q <= ST_RX_ACK;
              end else if (sh_q[BYTE_W-1:1] == SLAVE_ADDR) begin
                rw_q    <= sh_q[0];
                state_q <= ST_ADDR_ACK;
              end else begin
                state_q <= ST_SKIP;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              cnt_q <= '0;
              if (rw_q) begin
                sh_q    <= tx_byte;
                tx_load <= 1'b1;
                state_q <= ST_TX;
              end else begin
                state_q <= ST_RX;
              end
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) state_q <= ST_RX;
          end
          ST_TX: begin
            if (scl_fall) begin
              sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
              cnt_q <= cnt_q + 1'b1;
              if (cnt_q == CNT_W'(BYTE_W - 1)) begin
                tx_done <= 1'b1;
                state_q <= ST_TX_ACK;
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              mnack_q <= sda_s;
            end else if (scl_fall) begin
              cnt_q <= '0;
              if (!mnack_q) begin
                sh_q    <= tx_byte;
                tx_load <= 1'b1;
                state_q <= ST_TX;
              end else begin
                state_q <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (state_q)
      ST_ADDR_ACK, ST_RX_ACK: sda_oe = 1'b1;
      ST_TX:                  sda_oe = ~sh_q[BYTE_W-1];
      default:                sda_oe = 1'b0;
    endcase
  end

  assign rx_byte   = sh_q;
  assign addressed = (state_q != ST_IDLE) && (state_q != ST_ADDR) && (state_q != ST_SKIP);

  // R2/R5: the slave never moves SDA during a stable SCL high phase
  a_r2_sda_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe));

  // R3/R4: capture, load and sent events come from distinct clocks
  a_r4_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_cap, tx_load, tx_done}));
endmodule

// File: rtl/i2c_slave_regs.sv
module i2c_slave_regs
  import i2c_stretch_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              stop_seen,
  input  logic              tx_load,
  input  logic              tx_done,
  input  logic              rx_cap,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic [BYTE_W-1:0] tx_byte,
  output logic [NFLAG-1:0]  flags,
  output logic              single_buf,
  output logic              rx_stall
);
  logic [BYTE_W-1:0] tx_q, rx_q;
  logic [1:0]        ctrl_q;
  logic [NFLAG-1:0]  set_v, clr_v;

  always_comb begin
    set_v          = '0;
    set_v[FL_STOP] = stop_seen;
    set_v[FL_TXE]  = tx_load;
    set_v[FL_TXD]  = tx_done;
    set_v[FL_RXF]  = rx_cap;
    clr_v = (reg_wr && reg_addr == OFS_STAT) ? reg_wdata[NFLAG-1:0] : '0;
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    logic fq;
    always_ff @(posedge clk) begin
      if (!rst_n) fq <= 1'b0;
      else        fq <= set_v[g] | (fq & ~clr_v[g]);
    end
    assign flags[g] = fq;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_q   <= '0;
      rx_q   <= '0;
      ctrl_q <= '0;
    end else begin
      if (reg_wr && reg_addr == OFS_TX)   tx_q   <= reg_wdata;
      if (reg_wr && reg_addr == OFS_CTRL) ctrl_q <= reg_wdata[1:0];
      if (rx_cap)                         rx_q   <= rx_byte;
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_TX:   reg_rdata = tx_q;
      OFS_RX:   reg_rdata = rx_q;
      OFS_CTRL: reg_rdata = {{(BYTE_W-2){1'b0}}, ctrl_q};
      default:  reg_rdata = {{(BYTE_W-NFLAG){1'b0}}, flags};
    endcase
  end

  assign tx_byte    = tx_q;
  assign single_buf = ctrl_q[CT_SBUF];
  assign rx_stall   = ctrl_q[CT_STALL];

  // R7: a write of 1 with no coincident event leaves the flag clear
  a_r7_w1c_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_STAT && reg_wdata[FL_RXF] && !rx_cap) |=> !flags[FL_RXF]);

  // R3: the receive register holds the byte presented at the capture pulse
  a_r3_rx_capture: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cap |=> (rx_q == $past(rx_byte)));
endmodule

// File: rtl/i2c_stretch_slave.sv
module i2c_stretch_slave
  import i2c_stretch_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR  = 7'h2A,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  output logic              scl_oe,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata
);
  logic [1:0] raw, line_s, line_r, line_f;
  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .line_i(raw[g]),
      .line_s(line_s[g]), .rise(line_r[g]), .fall(line_f[g]));
  end

  logic              stop_seen, tx_load, tx_done, rx_cap, addressed;
  logic              single_buf, rx_stall, hold_q, hold_want;
  logic [BYTE_W-1:0] rx_byte, tx_byte;
  logic [NFLAG-1:0]  flags;

  i2c_byte_engine #(.SLAVE_ADDR(SLAVE_ADDR)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .scl_s(line_s[0]), .scl_rise(line_r[0]), .scl_fall(line_f[0]),
    .sda_s(line_s[1]), .sda_rise(line_r[1]), .sda_fall(line_f[1]),
    .tx_byte(tx_byte), .sda_oe(sda_oe), .rx_byte(rx_byte),
    .rx_cap(rx_cap), .tx_load(tx_load), .tx_done(tx_done),
    .stop_seen(stop_seen), .addressed(addressed));

  i2c_slave_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .stop_seen(stop_seen), .tx_load(tx_load), .tx_done(tx_done),
    .rx_cap(rx_cap), .rx_byte(rx_byte), .tx_byte(tx_byte),
    .flags(flags), .single_buf(single_buf), .rx_stall(rx_stall));

  assign hold_want = addressed &&
                     ((single_buf && flags[FL_TXE]) || (rx_stall && flags[FL_RXF]));

  // A hold may begin only while SCL is already low; once on it lasts until the cause goes
  always_ff @(posedge clk) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_want && (hold_q || !line_s[0]);
  end

  assign scl_oe = hold_q;

  // R8/R9: SCL is let go only after the pending flag that caused the stretch is cleared
  a_r8_release_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_oe) |-> !(addressed && single_buf && flags[FL_TXE]) &&
                      !(addressed && rx_stall && flags[FL_RXF]));

  // R9: a pending received byte with stall enabled engages the hold while SCL is low
  a_r9_stall_engages: assert property (@(posedge clk) disable iff (!rst_n)
    (addressed && rx_stall && flags[FL_RXF] && !line_s[0]) |=> scl_oe);
endmodule

// File: tb/i2c_stretch_slave_tb.sv
`timescale 1ns/1ps
module i2c_stretch_slave_tb;
  localparam logic [6:0] OWN = 7'h2A;
  localparam int H = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic scl_oe, sda_oe;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0, reg_rdata;
  wire scl_line = !(m_scl_low | scl_oe);
  wire sda_line = !(m_sda_low | sda_oe);
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  i2c_stretch_slave #(.SLAVE_ADDR(OWN)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .scl_oe(scl_oe),
    .sda_i(sda_line), .sda_oe(sda_oe), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  function automatic logic [7:0] addr_byte(input logic [6:0] a, input logic rd);
    return {a, rd};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic scl_pulse(output logic smp);
    m_scl_low = 1'b0;
    @(negedge clk);
    while (!scl_line) @(negedge clk);
    wait_clk(H / 2);
    smp = sda_line;
    wait_clk(H / 2);
    m_scl_low = 1'b1;
    wait_clk(H);
  endtask

  task automatic bus_start();
    m_sda_low = 1'b0; m_scl_low = 1'b0; wait_clk(H);
    m_sda_low = 1'b1; wait_clk(H);
    m_scl_low = 1'b1; wait_clk(H);
  endtask

  task automatic bus_stop();
    logic s;
    m_sda_low = 1'b1; wait_clk(4);
    m_scl_low = 1'b0;
    @(negedge clk);
    while (!scl_line) @(negedge clk);
    wait_clk(H);
    m_sda_low = 1'b0; wait_clk(H);
    s = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      m_sda_low = !b[i]; wait_clk(4);
      scl_pulse(s);
    end
    m_sda_low = 1'b0; wait_clk(4);
    scl_pulse(s);
    ack = !s;
  endtask

  task automatic rd_byte(output logic [7:0] b, input logic give_ack);
    logic s;
    m_sda_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      wait_clk(4);
      scl_pulse(s);
      b[i] = s;
    end
    m_sda_low = give_ack; wait_clk(4);
    scl_pulse(s);
    m_sda_low = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, b;
    logic ack, s;
    int seed;
    seed = $urandom(32'h1C2B);

    wait_clk(10);
    rst_n = 1'b1;
    wait_clk(4);
    check(scl_oe == 1'b0 && sda_oe == 1'b0, "R1 lines released", {scl_oe, sda_oe}, 0);
    reg_read(2'd3, d); check(d == 8'h00, "R1 status reset", d, 0);
    reg_read(2'd2, d); check(d == 8'h00, "R1 control reset", d, 0);
    reg_read(2'd1, d); check(d == 8'h00, "R1 rx data reset", d, 0);

    // directed write of one byte
    bus_start();
    wr_byte(addr_byte(OWN, 1'b0), ack); check(ack, "R2 own address ack", ack, 1);
    wr_byte(8'hA5, ack);               check(ack, "R3 data ack", ack, 1);
    reg_read(2'd3, d); check(d[3] == 1'b1, "R3 rx flag set", d, 8'h08);
    reg_read(2'd1, d); check(d == 8'hA5, "R3 rx data", d, 8'hA5);
    reg_write(2'd3, 8'h00);
    reg_read(2'd3, d); check(d[3] == 1'b1, "R7 zero write keeps flag", d, 8'h08);
    reg_write(2'd3, 8'h08);
    reg_read(2'd3, d); check(d == 8'h00, "R7 w1c clears flag", d, 0);
    bus_stop();
    reg_read(2'd3, d); check(d == 8'h01, "R6 stop flag", d, 1);
    reg_write(2'd3, 8'h0F);

    // address mismatch
    bus_start();
    wr_byte(addr_byte(OWN ^ 7'h11, 1'b0), ack); check(!ack, "R2 foreign address nack", ack, 0);
    wr_byte(8'h00, ack); check(!ack, "R2 foreign data nack", ack, 0);
    bus_stop();
    reg_read(2'd3, d); check(d == 8'h01, "R2 no transfer flags", d, 1);
    reg_write(2'd3, 8'h0F);

    // directed read with NACK ending
    reg_write(2'd0, 8'h3C);
    bus_start();
    wr_byte(addr_byte(OWN, 1'b1), ack); check(ack, "R2 read address ack", ack, 1);
    reg_read(2'd3, d); check(d[1] == 1'b1, "R4 tx free flag", d, 8'h02);
    reg_write(2'd0, 8'hC3);
    reg_write(2'd3, 8'h0F);
    rd_byte(b, 1'b1); check(b == 8'h3C, "R4 first tx byte", b, 8'h3C);
    reg_read(2'd3, d); check(d[2] == 1'b1 && d[1] == 1'b1, "R4 sent and free flags", d, 8'h06);
    reg_write(2'd0, 8'h00);
    rd_byte(b, 1'b0); check(b == 8'hC3, "R4 second tx byte", b, 8'hC3);
    for (int k = 0; k < 9; k++) begin
      wait_clk(4);
      scl_pulse(s);
      check(s == 1'b1, "R5 sda released after nack", s, 1);
    end
    bus_stop();
    reg_write(2'd3, 8'h0F);

    // single-buffer stretch on transmit
    reg_write(2'd2, 8'h01);
    reg_write(2'd0, 8'h5A);
    bus_start();
    wr_byte(addr_byte(OWN, 1'b1), ack);
    fork
      rd_byte(b, 1'b0);
      begin
        wait_clk(40);
        check(scl_oe == 1'b1 && scl_line == 1'b0, "R8 scl held while tx free", scl_oe, 1);
        reg_write(2'd0, 8'h11);
        reg_write(2'd3, 8'h02);
        wait_clk(10);
        check(scl_oe == 1'b0, "R8 scl released after clear", scl_oe, 0);
      end
    join
    check(b == 8'h5A, "R8 byte after stretch", b, 8'h5A);
    bus_stop();
    reg_write(2'd2, 8'h00);
    reg_write(2'd3, 8'h0F);

    // receive stall
    reg_write(2'd2, 8'h02);
    bus_start();
    wr_byte(addr_byte(OWN, 1'b0), ack);
    fork
      wr_byte(8'h96, ack);
      begin
        d = 8'h00;
        while (d[3] == 1'b0) reg_read(2'd3, d);
        wait_clk(30);
        check(scl_oe == 1'b1, "R9 scl held after capture", scl_oe, 1);
        reg_read(2'd1, d); check(d == 8'h96, "R9 stalled rx data", d, 8'h96);
        reg_write(2'd3, 8'h08);
        wait_clk(10);
        check(scl_oe == 1'b0, "R9 scl released after clear", scl_oe, 0);
      end
    join
    check(ack, "R9 ack after stall", ack, 1);
    bus_stop();
    reg_write(2'd2, 8'h00);
    reg_write(2'd3, 8'h0F);

    // seeded random transfers
    for (int t = 0; t < 10; t++) begin
      logic [7:0] data [4];
      int n;
      logic rd;
      rd = 1'($urandom % 2);
      n  = 1 + ($urandom % 4);
      for (int k = 0; k < 4; k++) data[k] = 8'($urandom);
      if (rd) begin
        reg_write(2'd0, data[0]);
        bus_start();
        wr_byte(addr_byte(OWN, 1'b1), ack); check(ack, "R2 random read ack", ack, 1);
        for (int k = 0; k < n; k++) begin
          reg_write(2'd0, (k + 1 < n) ? data[k+1] : 8'h00);
          rd_byte(b, k + 1 < n);
          check(b == data[k], "R4 random tx byte", b, data[k]);
        end
      end else begin
        bus_start();
        wr_byte(addr_byte(OWN, 1'b0), ack); check(ack, "R2 random write ack", ack, 1);
        for (int k = 0; k < n; k++) begin
          wr_byte(data[k], ack); check(ack, "R3 random data ack", ack, 1);
          reg_read(2'd1, d); check(d == data[k], "R3 random rx data", d, data[k]);
          reg_read(2'd3, d); check(d[3] == 1'b1, "R3 random rx flag", d, 8'h08);
          reg_write(2'd3, 8'h08);
        end
      end
      bus_stop();
      reg_read(2'd3, d); check(d[0] == 1'b1, "R6 random stop flag", d, 1);
      reg_write(2'd3, 8'h0F);
      reg_read(2'd3, d); check(d == 8'h00, "R7 random clear all", d, 0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule